// File: doc/BRIEF.md
# Serial Port Interrupt Combiner

This block merges the six status events of a serial port into one interrupt request line. The events are transmit register empty, transmission complete, receive data ready, receive overrun, idle line and parity error. The datapath raises each event flag with a one-cycle pulse. Software lowers it with a dedicated clear strobe. Each flag is gated by an enable bit. Receive-ready and overrun share one enable. The OR of the gated flags is blocked by a global mask and then registered, so the request line cannot glitch.

A small power-mode state machine tracks three states. MODE_RUN is normal operation. MODE_WAIT is a light sleep, which any enabled flag ends through a wake request. MODE_HALT freezes every flag, every enable and the request line, and pauses the transfer logic. The transitions are named as follows:
- RUN_TO_WAIT on a wait entry pulse.
- RUN_TO_HALT on a halt entry pulse, which takes priority over wait entry.
- WAIT_TO_RUN when an enabled flag is present.
- WAIT_TO_HALT on a halt entry pulse, which takes priority over the wake.
- HALT_TO_RUN on a halt exit pulse.

No event leaves MODE_HALT.

Top module: `sci_irq_combiner`

## Requirements
- R1: After reset all flags are 0, irq_o and wake_o are 0, mode_o is 0 (RUN) and pause_o is 0.
- R2: A 1 on evt_set[i] sets flags_o[i] at the next clock edge, and the flag then stays set. A 1 on evt_clr[i] clears it at the next edge. Flag bit positions are 0 transmit empty, 1 transmit complete, 2 receive ready, 3 overrun, 4 idle, 5 parity error.
- R3: When evt_set[i] and evt_clr[i] are both 1 in the same cycle, the flag ends up set.
- R4: irq_o rises one clock edge after a flag becomes set while its enable is 1 and glob_mask is 0. It falls one edge after the last such source goes away.
- R5: The enable bits are loaded from en_wdata when en_wr is 1. Enable bit 0 gates flag 0, bit 1 gates flag 1, bit 2 gates both flag 2 and flag 3, bit 3 gates flag 4, and bit 4 gates flag 5.
- R6: While glob_mask is 1, irq_o is 0. The flags are not changed by the mask.
- R7: In RUN, a wait_enter pulse moves mode_o to 1 (WAIT) at the next edge.
- R8: In WAIT, wake_o is 1 in any cycle where an enabled flag is set, whatever glob_mask is. The mode returns to RUN at the next edge. wake_o is 0 outside WAIT.
- R9: A halt_enter pulse in RUN or WAIT moves mode_o to 2 (HALT) and raises pause_o. In HALT, evt_set, evt_clr and en_wr are ignored, and flags_o, the enables and irq_o hold their values.
- R10: In HALT only halt_exit returns the mode to RUN. halt_enter wins over wait_enter in RUN, and over a wake in WAIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_set | input | 6 | Per-event set pulses from the datapath |
| evt_clr | input | 6 | Per-event software clear strobes |
| en_wr | input | 1 | Load strobe for the enable bits |
| en_wdata | input | 5 | New enable bits |
| glob_mask | input | 1 | Global interrupt mask, 1 blocks irq_o |
| wait_enter | input | 1 | Request to enter WAIT |
| halt_enter | input | 1 | Request to enter HALT |
| halt_exit | input | 1 | Request to leave HALT |
| irq_o | output | 1 | Registered combined interrupt request |
| wake_o | output | 1 | Wake-from-wait request |
| flags_o | output | 6 | Current event flags |
| mode_o | output | 2 | Power mode: 0 RUN, 1 WAIT, 2 HALT |
| pause_o | output | 1 | Transfer pause while in HALT |

## Verification
An enable routed to the wrong flag shows at irq_o two edges after the flag is pulsed, because the request then rises or stays low against the mapping. A freeze that leaks lets flags_o change within one edge of a set pulse during HALT. A lost enable reappears as a missing irq_o right after halt_exit. A wrong next-state decision shows on mode_o at the very next edge, and wake_o in a state other than WAIT is visible in the same cycle.

// File: rtl/sci_irq_pkg.sv
package sci_irq_pkg;
    localparam int NUM_EVT = 6;
    localparam int NUM_EN  = 5;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'd0,
        MODE_WAIT = 2'd1,
        MODE_HALT = 2'd2
    } pwr_mode_e;

    // enable index that gates a given event flag
    function automatic int en_index(input int evt);
        case (evt)
            0:       return 0;
            1:       return 1;
            2, 3:    return 2;
            4:       return 3;
            default: return 4;
        endcase
    endfunction
endpackage

// File: rtl/sci_flag_bank.sv
module sci_flag_bank #(
    parameter int NUM_EVT = 6,
    parameter int NUM_EN  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frozen,
    input  logic [NUM_EVT-1:0] evt_set,
    input  logic [NUM_EVT-1:0] evt_clr,
    input  logic               en_wr,
    input  logic [NUM_EN-1:0]  en_wdata,
    output logic [NUM_EVT-1:0] flags,
    output logic [NUM_EN-1:0]  enables
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags   <= '0;
            enables <= '0;
        end else if (!frozen) begin
            flags <= evt_set | (flags & ~evt_clr);
            if (en_wr) begin
                enables <= en_wdata;
            end
        end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!frozen && evt_set[0] && evt_clr[0]) |=> flags[0]); // R3
    AST_FROZEN_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |=> $stable(flags)); // R9
    AST_FROZEN_EN: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |=> $stable(enables)); // R9
endmodule

// File: rtl/sci_irq_gate.sv
module sci_irq_gate #(
    parameter int NUM_EVT = 6,
    parameter int NUM_EN  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frozen,
    input  logic               glob_mask,
    input  logic [NUM_EVT-1:0] flags,
    input  logic [NUM_EN-1:0]  enables,
    output logic               any_enabled,
    output logic               irq
);
    import sci_irq_pkg::*;

    logic [NUM_EVT-1:0] gated;

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_gate
        assign gated[g] = flags[g] & enables[en_index(g)];
    end

    assign any_enabled = |gated;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (!frozen) begin
            irq <= any_enabled & ~glob_mask;
        end
    end

    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!frozen && glob_mask) |=> !irq); // R6
    AST_NO_SOURCE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!frozen && flags == '0) |=> !irq); // R4
    AST_FROZEN_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |=> $stable(irq)); // R9
endmodule

// File: rtl/sci_pwr_fsm.sv
module sci_pwr_fsm (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wait_enter,
    input  logic       halt_enter,
    input  logic       halt_exit,
    input  logic       any_enabled,
    output logic       frozen,
    output logic       wake,
    output logic [1:0] mode
);
    import sci_irq_pkg::*;

    pwr_mode_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_RUN: begin
                if (halt_enter)      state_d = MODE_HALT;
                else if (wait_enter) state_d = MODE_WAIT;
            end
            MODE_WAIT: begin
                if (halt_enter)       state_d = MODE_HALT;
                else if (any_enabled) state_d = MODE_RUN;
            end
            MODE_HALT: begin
                if (halt_exit) state_d = MODE_RUN;
            end
            default: state_d = MODE_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        frozen = (state_q == MODE_HALT);
        wake   = (state_q == MODE_WAIT) && any_enabled;
        mode   = state_q;
    end

    AST_WAKE_ONLY_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (mode == 2'd1)); // R8
    AST_WAKE_RETURNS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (wake && !halt_enter) |=> (mode == 2'd0)); // R8
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !halt_exit) |=> frozen); // R10
    AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        halt_enter |=> frozen); // R9
endmodule

// File: rtl/sci_irq_combiner.sv
module sci_irq_combiner #(
    parameter int NUM_EVT = sci_irq_pkg::NUM_EVT,
    parameter int NUM_EN  = sci_irq_pkg::NUM_EN
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_set,
    input  logic [NUM_EVT-1:0] evt_clr,
    input  logic               en_wr,
    input  logic [NUM_EN-1:0]  en_wdata,
    input  logic               glob_mask,
    input  logic               wait_enter,
    input  logic               halt_enter,
    input  logic               halt_exit,
    output logic               irq_o,
    output logic               wake_o,
    output logic [NUM_EVT-1:0] flags_o,
    output logic [1:0]         mode_o,
    output logic               pause_o
);
    logic              frozen;
    logic              any_enabled;
    logic [NUM_EN-1:0] enables;

    sci_flag_bank #(.NUM_EVT(NUM_EVT), .NUM_EN(NUM_EN)) u_bank (
        .clk(clk), .rst_n(rst_n), .frozen(frozen),
        .evt_set(evt_set), .evt_clr(evt_clr),
        .en_wr(en_wr), .en_wdata(en_wdata),
        .flags(flags_o), .enables(enables)
    );

    sci_irq_gate #(.NUM_EVT(NUM_EVT), .NUM_EN(NUM_EN)) u_gate (
        .clk(clk), .rst_n(rst_n), .frozen(frozen), .glob_mask(glob_mask),
        .flags(flags_o), .enables(enables),
        .any_enabled(any_enabled), .irq(irq_o)
    );

    sci_pwr_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .wait_enter(wait_enter), .halt_enter(halt_enter), .halt_exit(halt_exit),
        .any_enabled(any_enabled),
        .frozen(frozen), .wake(wake_o), .mode(mode_o)
    );

    assign pause_o = frozen;

    AST_PAUSE_MATCHES_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        pause_o |-> (mode_o == 2'd2)); // R9
endmodule

// File: tb/test_sci_irq_combiner.sv
module test_sci_irq_combiner;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] evt_set = '0, evt_clr = '0;
    logic       en_wr = 1'b0;
    logic [4:0] en_wdata = '0;
    logic       glob_mask = 1'b0, wait_enter = 1'b0, halt_enter = 1'b0, halt_exit = 1'b0;
    logic       irq_o, wake_o, pause_o;
    logic [5:0] flags_o;
    logic [1:0] mode_o;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    sci_irq_combiner i_sci_irq_combiner (
        .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .evt_clr(evt_clr),
        .en_wr(en_wr), .en_wdata(en_wdata), .glob_mask(glob_mask),
        .wait_enter(wait_enter), .halt_enter(halt_enter), .halt_exit(halt_exit),
        .irq_o(irq_o), .wake_o(wake_o), .flags_o(flags_o), .mode_o(mode_o),
        .pause_o(pause_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // expected enable bit for each flag
    function automatic int exp_en(input int e);
        case (e)
            0: return 0;
            1: return 1;
            2: return 2;
            3: return 2;
            4: return 3;
            default: return 4;
        endcase
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse_set(input logic [5:0] s, input logic [5:0] c);
        evt_set = s; evt_clr = c; step();
        evt_set = '0; evt_clr = '0;
    endtask

    task automatic write_en(input logic [4:0] v);
        en_wr = 1'b1; en_wdata = v; step();
        en_wr = 1'b0;
    endtask

    task automatic clear_all();
        pulse_set(6'h00, 6'h3f); step();
    endtask

    task automatic t_reset();
        chk("R1 flags", flags_o, 0);
        chk("R1 irq", irq_o, 0);
        chk("R1 wake", wake_o, 0);
        chk("R1 mode", mode_o, 0);
        chk("R1 pause", pause_o, 0);
    endtask

    task automatic t_set_clear();
        pulse_set(6'b010100, 6'h00);
        chk("R2 set", flags_o, 6'b010100);
        step(); step();
        chk("R2 hold", flags_o, 6'b010100);
        pulse_set(6'h00, 6'b000100);
        chk("R2 clear", flags_o, 6'b010000);
        clear_all();
        chk("R2 clear all", flags_o, 0);
    endtask

    task automatic t_set_wins();
        pulse_set(6'b100001, 6'b100001);
        chk("R3 set wins", flags_o, 6'b100001);
        clear_all();
    endtask

    task automatic t_irq_timing();
        write_en(5'b00001);
        pulse_set(6'b000001, 6'h00);
        chk("R4 irq not yet", irq_o, 0);
        step();
        chk("R4 irq rises", irq_o, 1);
        pulse_set(6'h00, 6'b000001);
        chk("R4 irq still high", irq_o, 1);
        step();
        chk("R4 irq falls", irq_o, 0);
        write_en(5'b00000);
    endtask

    task automatic t_mapping();
        for (int e = 0; e < 6; e++) begin
            write_en(5'(1 << exp_en(e)));
            pulse_set(6'(1 << e), 6'h00);
            step();
            chk($sformatf("R5 evt%0d own enable", e), irq_o, 1);
            write_en(5'h1f ^ 5'(1 << exp_en(e)));
            step(); step();
            chk($sformatf("R5 evt%0d other enables", e), irq_o, 0);
            clear_all();
        end
        write_en(5'b00000);
    endtask

    task automatic t_mask();
        write_en(5'b01000);
        glob_mask = 1'b1;
        pulse_set(6'b010000, 6'h00);
        step(); step();
        chk("R6 masked irq", irq_o, 0);
        chk("R6 flag kept", flags_o, 6'b010000);
        glob_mask = 1'b0;
        step(); step();
        chk("R6 unmasked irq", irq_o, 1);
        clear_all();
        write_en(5'b00000);
        step();
    endtask

    task automatic t_wait_wake();
        write_en(5'b00100);
        glob_mask = 1'b1;
        wait_enter = 1'b1; step(); wait_enter = 1'b0;
        chk("R7 enter wait", mode_o, 1);
        chk("R8 no wake yet", wake_o, 0);
        pulse_set(6'b001000, 6'h00);
        chk("R8 wake on overrun", wake_o, 1);
        chk("R8 still wait", mode_o, 1);
        step();
        chk("R8 back to run", mode_o, 0);
        chk("R8 wake low in run", wake_o, 0);
        glob_mask = 1'b0;
        clear_all();
        write_en(5'b00000);
        step();
    endtask

    task automatic t_halt();
        write_en(5'b00001);
        pulse_set(6'b000001, 6'h00);
        step();
        chk("R9 irq before halt", irq_o, 1);
        halt_enter = 1'b1; step(); halt_enter = 1'b0;
        chk("R9 mode halt", mode_o, 2);
        chk("R9 pause", pause_o, 1);
        evt_set = 6'b100000; evt_clr = 6'b000001;
        en_wr = 1'b1; en_wdata = 5'b00000; glob_mask = 1'b1;
        wait_enter = 1'b1;
        step(); step();
        evt_set = '0; evt_clr = '0; en_wr = 1'b0; wait_enter = 1'b0; glob_mask = 1'b0;
        chk("R9 flags frozen", flags_o, 6'b000001);
        chk("R9 irq frozen", irq_o, 1);
        chk("R10 stays halt", mode_o, 2);
        chk("R9 no wake", wake_o, 0);
        halt_exit = 1'b1; step(); halt_exit = 1'b0;
        chk("R10 exit to run", mode_o, 0);
        chk("R10 pause low", pause_o, 0);
        step();
        chk("R9 enable kept", irq_o, 1);
        halt_enter = 1'b1; wait_enter = 1'b1; step();
        halt_enter = 1'b0; wait_enter = 1'b0;
        chk("R10 halt beats wait", mode_o, 2);
        halt_exit = 1'b1; step(); halt_exit = 1'b0;
        wait_enter = 1'b1; step(); wait_enter = 1'b0;
        chk("R10 wait with flag", mode_o, 1);
        halt_enter = 1'b1; step(); halt_enter = 1'b0;
        chk("R10 halt beats wake", mode_o, 2);
        halt_exit = 1'b1; step(); halt_exit = 1'b0;
        clear_all();
        write_en(5'b00000);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        step(); step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_set_clear();
        t_set_wins();
        t_irq_timing();
        t_mapping();
        t_mask();
        t_wait_wake();
        t_halt();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule